// File: doc/BRIEF.md
# Credit-based request throttle

This block sits on the path from one bus master into a shared on-chip network. It caps how many request transactions that master may have in flight toward a shared slave. The cap is a credit count. Each accepted request spends one credit, and each reply handed back to the master refunds one. While no credit remains, the master sees its request ready held low, even if the network could take more. Requests therefore cannot pile up in the shared buffering of the network.

In a system with several masters sharing one slave, one instance is placed at each master. Request and reply payloads pass through unchanged. The only added control is the credit gate on the request side and the credit refund on the reply side. A reply that arrives while every credit is already home is treated as a protocol fault. It sets a sticky error flag and is not counted.

Top module: `credit_throttle`

## Requirements
- R1: After reset the block holds CREDITS credits (CREDITS is a parameter, at least 1) and `credit_err` is 0. With `n_req_ready` high, exactly CREDITS back-to-back requests are then accepted.
- R2: `m_req_ready` equals `n_req_ready` AND (credits > 0). `n_req_valid` equals `m_req_valid` AND (credits > 0). `n_req_data` equals `m_req_data`. A request is issued in a cycle where `m_req_valid` and `m_req_ready` are both 1.
- R3: With no reply returned, at most CREDITS requests are issued. After that, `m_req_ready` and `n_req_valid` stay 0.
- R4: The reply channel passes straight through: `m_rsp_valid` = `n_rsp_valid`, `n_rsp_ready` = `m_rsp_ready`, `m_rsp_data` = `n_rsp_data`. A reply handshake (`m_rsp_valid` and `m_rsp_ready` both 1) refunds one credit, which can be used from the next cycle.
- R5: When a request is issued and a reply handshake happens in the same cycle, the credit count is unchanged.
- R6: A reply handshake while all CREDITS credits are present sets `credit_err` from the next cycle until reset. That reply does not raise the count above CREDITS.
- R7: A reply offered while `m_rsp_ready` is 0 refunds no credit.
- R8: A request offered while `n_req_ready` is 0 is not issued and spends no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Master request ready (network ready and credit available) |
| m_req_data | input | DATA_W | Master request payload |
| n_req_valid | output | 1 | Request valid toward the network |
| n_req_ready | input | 1 | Network request ready |
| n_req_data | output | DATA_W | Request payload toward the network |
| n_rsp_valid | input | 1 | Reply valid from the network |
| n_rsp_ready | output | 1 | Reply ready toward the network |
| n_rsp_data | input | RSP_W | Reply payload from the network |
| m_rsp_valid | output | 1 | Reply valid to the master |
| m_rsp_ready | input | 1 | Master reply ready |
| m_rsp_data | output | RSP_W | Reply payload to the master |
| credit_err | output | 1 | Sticky flag: reply returned with no credit outstanding |

## Verification
The bench builds two instances side by side with 8-bit payloads, one with CREDITS=3 and one with CREDITS=1, and drives both with the same inputs. With so few credits, a short walk through all sixteen combinations of the four handshake inputs reaches the empty, full and middle counts many times. With CREDITS=1 the empty and full states are adjacent, so a simultaneous issue and refund, and a spurious reply, land on both limits at once. An arithmetic credit model per instance predicts every output in every cycle.

// File: rtl/credit_throttle_pkg.sv
package credit_throttle_pkg;

  typedef enum logic [1:0] {
    CR_HOLD  = 2'd0,
    CR_SPEND = 2'd1,
    CR_REFUND = 2'd2
  } credit_act_e;

  function automatic int credit_cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/credit_ledger.sv
module credit_ledger
  import credit_throttle_pkg::*;
#(
  parameter int CREDITS = 4,
  localparam int CW = credit_cnt_w(CREDITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic spend,
  input  logic refund,
  output logic avail,
  output logic err
);

  localparam logic [CW-1:0] FULL = CW'(CREDITS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q;
  logic          refund_ok;
  credit_act_e   act;

  assign refund_ok = refund & ~full_q;

  always_comb begin
    unique case ({spend, refund_ok})
      2'b10:   act = CR_SPEND;
      2'b01:   act = CR_REFUND;
      default: act = CR_HOLD;
    endcase
  end

  always_comb begin
    unique case (act)
      CR_SPEND:  cnt_d = cnt_q - CW'(1);
      CR_REFUND: cnt_d = cnt_q + CW'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= FULL;
      avail  <= 1'b1;
      full_q <= 1'b1;
      err    <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      avail  <= (cnt_d != '0);
      full_q <= (cnt_d == FULL);
      if (refund && full_q)
        err <= 1'b1;
    end
  end

  // R3: a spend request never arrives with an empty ledger
  a_r3_spend_needs_credit: assert property (@(posedge clk) disable iff (rst)
    spend |-> (cnt_q != '0));

  // R3: a lone spend removes exactly one credit
  a_r3_spend_dec: assert property (@(posedge clk) disable iff (rst)
    (spend && !refund) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R4: a lone refund below the cap adds exactly one credit
  a_r4_refund_inc: assert property (@(posedge clk) disable iff (rst)
    (refund && !spend && cnt_q != FULL) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R5: spend and refund together leave the count alone
  a_r5_both_hold: assert property (@(posedge clk) disable iff (rst)
    (spend && refund && cnt_q != FULL) |=> (cnt_q == $past(cnt_q)));

  // R6: the count never exceeds the cap
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (cnt_q <= FULL));

  // R6: a refund at the cap raises the error flag
  a_r6_err_on_spurious: assert property (@(posedge clk) disable iff (rst)
    (refund && cnt_q == FULL) |=> err);

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: rtl/credit_req_gate.sv
module credit_req_gate #(
  parameter int DATA_W = 64
) (
  input  logic              avail,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [DATA_W-1:0] m_data,
  output logic              n_valid,
  input  logic              n_ready,
  output logic [DATA_W-1:0] n_data,
  output logic              spend
);

  assign m_ready = n_ready & avail;
  assign n_valid = m_valid & avail;
  assign n_data  = m_data;
  assign spend   = m_valid & n_ready & avail;

endmodule

// File: rtl/credit_reply_path.sv
module credit_reply_path #(
  parameter int RSP_W = 64
) (
  input  logic             n_valid,
  output logic             n_ready,
  input  logic [RSP_W-1:0] n_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [RSP_W-1:0] m_data,
  output logic             refund
);

  assign m_valid = n_valid;
  assign n_ready = m_ready;
  assign m_data  = n_data;
  assign refund  = n_valid & m_ready;

endmodule

// File: rtl/credit_throttle.sv
module credit_throttle #(
  parameter int CREDITS = 4,
  parameter int DATA_W  = 64,
  parameter int RSP_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_req_valid,
  output logic              m_req_ready,
  input  logic [DATA_W-1:0] m_req_data,
  output logic              n_req_valid,
  input  logic              n_req_ready,
  output logic [DATA_W-1:0] n_req_data,
  input  logic              n_rsp_valid,
  output logic              n_rsp_ready,
  input  logic [RSP_W-1:0]  n_rsp_data,
  output logic              m_rsp_valid,
  input  logic              m_rsp_ready,
  output logic [RSP_W-1:0]  m_rsp_data,
  output logic              credit_err
);

  generate
    if (CREDITS < 1) begin : g_bad_cfg
      $error("credit_throttle: CREDITS must be at least 1");
    end
  endgenerate

  logic avail, spend, refund;

  credit_req_gate #(.DATA_W(DATA_W)) req_gate_i (
    .avail   (avail),
    .m_valid (m_req_valid),
    .m_ready (m_req_ready),
    .m_data  (m_req_data),
    .n_valid (n_req_valid),
    .n_ready (n_req_ready),
    .n_data  (n_req_data),
    .spend   (spend)
  );

  credit_reply_path #(.RSP_W(RSP_W)) rsp_path_i (
    .n_valid (n_rsp_valid),
    .n_ready (n_rsp_ready),
    .n_data  (n_rsp_data),
    .m_valid (m_rsp_valid),
    .m_ready (m_rsp_ready),
    .m_data  (m_rsp_data),
    .refund  (refund)
  );

  credit_ledger #(.CREDITS(CREDITS)) ledger_i (
    .clk    (clk),
    .rst    (rst),
    .spend  (spend),
    .refund (refund),
    .avail  (avail),
    .err    (credit_err)
  );

  // R2: the master is never told ready unless the network is ready
  a_r2_ready_needs_net: assert property (@(posedge clk) disable iff (rst)
    m_req_ready |-> n_req_ready);

  // R2: a request toward the network is always one the master offered
  a_r2_valid_from_master: assert property (@(posedge clk) disable iff (rst)
    n_req_valid |-> m_req_valid);

endmodule

// File: tb/credit_throttle_tb_top.sv
module credit_throttle_tb_top;

  localparam int DW = 8;
  localparam int CAP0 = 3;
  localparam int CAP1 = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic mval, nrdy, rspv, mrspr;
  logic [DW-1:0] mdata, rdata;

  logic [1:0] o_mrdy, o_nval, o_nrspr, o_mrspv, o_err;
  logic [DW-1:0] o_ndata [2];
  logic [DW-1:0] o_mrdata [2];

  credit_throttle #(.CREDITS(CAP0), .DATA_W(DW), .RSP_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .m_req_valid(mval), .m_req_ready(o_mrdy[0]), .m_req_data(mdata),
    .n_req_valid(o_nval[0]), .n_req_ready(nrdy), .n_req_data(o_ndata[0]),
    .n_rsp_valid(rspv), .n_rsp_ready(o_nrspr[0]), .n_rsp_data(rdata),
    .m_rsp_valid(o_mrspv[0]), .m_rsp_ready(mrspr), .m_rsp_data(o_mrdata[0]),
    .credit_err(o_err[0])
  );

  credit_throttle #(.CREDITS(CAP1), .DATA_W(DW), .RSP_W(DW)) dut1_i (
    .clk(clk), .rst(rst),
    .m_req_valid(mval), .m_req_ready(o_mrdy[1]), .m_req_data(mdata),
    .n_req_valid(o_nval[1]), .n_req_ready(nrdy), .n_req_data(o_ndata[1]),
    .n_rsp_valid(rspv), .n_rsp_ready(o_nrspr[1]), .n_rsp_data(rdata),
    .m_rsp_valid(o_mrspv[1]), .m_rsp_ready(mrspr), .m_rsp_data(o_mrdata[1]),
    .credit_err(o_err[1])
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cap_m [2] = '{CAP0, CAP1};
  int cnt_m [2];
  bit err_m [2];

  task automatic chk(input string tag, input int d, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s dut%0d: actual %0d expected %0d", tag, d, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; mval = 0; nrdy = 0; rspv = 0; mrspr = 0; mdata = '0; rdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < 2; d++) begin cnt_m[d] = cap_m[d]; err_m[d] = 0; end
  endtask

  // drive one cycle, check every output of both instances against the model
  task automatic step(input logic v, input logic nr, input logic rv, input logic mr,
                      input string tag);
    bit iss [2];
    bit ret [2];
    @(negedge clk);
    mval = v; nrdy = nr; rspv = rv; mrspr = mr;
    mdata = mdata + 8'd37; rdata = rdata ^ 8'h5a ^ mdata;
    #1;
    for (int d = 0; d < 2; d++) begin
      chk({tag, " R2 m_req_ready"}, d, o_mrdy[d], int'(nr && cnt_m[d] > 0));
      chk({tag, " R2 n_req_valid"}, d, o_nval[d], int'(v && cnt_m[d] > 0));
      chk("R2 n_req_data", d, o_ndata[d], mdata);
      chk("R4 n_rsp_ready", d, o_nrspr[d], mr);
      chk("R4 m_rsp_valid", d, o_mrspv[d], rv);
      chk("R4 m_rsp_data", d, o_mrdata[d], rdata);
      chk({tag, " R6 credit_err"}, d, o_err[d], err_m[d]);
      iss[d] = v && nr && cnt_m[d] > 0;
      ret[d] = rv && mr;
    end
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      if (ret[d] && cnt_m[d] == cap_m[d]) err_m[d] = 1;
      cnt_m[d] = cnt_m[d] - int'(iss[d]) +
                 int'(ret[d] && cnt_m[d] != cap_m[d]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] lfsr;
    do_reset();
    // R1: reset state, then exactly CREDITS issues back to back
    step(0, 1, 0, 0, "R1");
    // R8: requests refused by the network cost nothing
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R8");
    for (int i = 0; i < CAP0; i++) step(1, 1, 0, 0, "R1");
    // R3: no further issue with no reply
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R3");
    // R7: a reply not taken by the master refunds nothing
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, "R7");
    // R4: one refund gives exactly one issue
    step(0, 1, 1, 1, "R4");
    step(1, 1, 0, 0, "R4");
    step(1, 1, 0, 0, "R4");
    // R5: bring one credit back, then spend and refund together
    step(0, 1, 1, 1, "R5");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, "R5");
    step(1, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R5");
    // R6: refill, then one spurious reply
    for (int i = 0; i < CAP0; i++) step(0, 1, 1, 1, "R6");
    step(0, 1, 1, 1, "R6");
    step(0, 1, 0, 0, "R6");
    for (int i = 0; i < CAP0 + 2; i++) step(1, 1, 0, 0, "R6");
    // sweep: all 16 input combinations from every reachable count
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int pre = 0; pre <= CAP0; pre++) begin
        for (int c = 0; c < 16; c++) begin
          for (int k = 0; k < pre; k++) step(1, 1, 0, 0, "SWEEP");
          step(c[0], c[1], c[2], c[3], "SWEEP");
          for (int k = 0; k < CAP0; k++) step(0, 1, 1, 1, "SWEEP");
          if (r[0]) step(0, 1, 0, 0, "SWEEP");
        end
      end
    end
    // pseudo-random traffic
    do_reset();
    lfsr = 8'hc3;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (i % 200 == 0) do_reset();
      step(lfsr[0], lfsr[1] | lfsr[4], lfsr[2] & (cnt_m[0] != CAP0),
           lfsr[3] | lfsr[6], "RAND");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule